// File: doc/BRIEF.md
# Two-Channel Debug Break Comparator

This block sits next to a processor core and watches two streams: the bus cycles the core issues (instruction fetches and operand accesses) and the reports of instructions that have completed. Software programs an address and an address mask into each of two channels. Channel B also holds a data value and a per-bit data mask. When an observed cycle satisfies a channel's condition, the block records a sticky match flag for that channel. If the debug function is enabled, the block also raises a break request towards the core's exception logic.

Each channel picks its own break timing. A channel set for a pre-execution break compares instruction fetches as they are observed, and requests the break in that same cycle. A channel set for a post-execution break compares completion reports, and requests the break in the cycle after the report. The two channels either act as independent break sources, or they are chained. In chained mode a channel A match only arms the chain. The break fires on a later channel B match.

For byte-sized data breaks, software copies the byte into both halves of the low 16 bits of the data and data-mask registers. The comparator itself always compares full words.

Top module: `dbgbrk_top`

## Requirements
- R1: After power-on reset, both match flags (control bits 15 and 14) and the debug enable (control bit 0) read as 0, and `brk_req` is low.
- R2: Register select 1..6 (A address, A address mask, B address, B address mask, B data, B data mask) read back the last value written. In the control register (select 0) every bit other than 15, 14, 10, 7, 6, 3 and 0 reads 0 whatever was written. Bits 10, 7, 6 and 3 read back as written.
- R3: An address compare ignores every address bit whose mask bit is 1 and requires equality on every bit whose mask bit is 0.
- R4: When control bit 7 is 1, channel B also requires the observed data to equal the B data register on every bit whose B data-mask bit is 0. When bit 7 is 0, the data is ignored.
- R5: A channel whose post-select bit is 0 (bit 10 for A, bit 6 for B) compares only cycles with `bus_valid` and `bus_ifetch` both 1, against `bus_addr`/`bus_data`. A match requests the break in that same cycle. Operand cycles (`bus_ifetch` 0) never match such a channel.
- R6: A channel whose post-select bit is 1 compares `ret_addr`/`ret_data` when `ret_valid` is 1. A match requests the break in the following cycle, not in the cycle of the report.
- R7: With control bit 3 at 0, a match on either channel requests a break.
- R8: With control bit 3 at 1, a channel A match arms the chain without a break. A channel B match requests a break only while the chain is armed, and that match disarms it. A channel B match without prior arming gives no break. A simultaneous channel A match re-arms the chain.
- R9: A channel's flag sets in the cycle after its match and stays set. Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R10: With control bit 0 at 0, `brk_req` stays low, while the match flags still record matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 A address, 2 A address mask, 3 B address, 4 B address mask, 5 B data, 6 B data mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| bus_valid | input | 1 | An observed bus cycle is present |
| bus_ifetch | input | 1 | The observed cycle is an instruction fetch (0: operand access) |
| bus_addr | input | 32 | Address of the observed cycle |
| bus_data | input | 32 | Data of the observed cycle |
| ret_valid | input | 1 | An instruction completed this cycle |
| ret_addr | input | 32 | Address of the completed instruction |
| ret_data | input | 32 | Data associated with the completed instruction |
| brk_req | output | 1 | Break request to the core |

## Verification
The assertions assume that the unreset control bits (post selects, data-compare enable, chain select) are programmed before any bus or completion activity reaches the block. Until then those bits are unknown, and the properties that depend on them are not meaningful. They also assume that `bus_ifetch` and the data inputs are driven whenever their valid strobe is high. The bench meets both assumptions: its first action after reset is a control write, and it always drives every observation input to a known value. Random traffic draws addresses and data near the programmed values, so that masked and unmasked bit differences both occur often. Control rewrites land in arbitrary cycles, including cycles that carry matches.

// File: rtl/dbgbrk_pkg.sv
package dbgbrk_pkg;

  localparam int CTRL_W     = 16;
  localparam int CMP_MAX_W  = 64;

  // control register field positions (software-visible)
  localparam int BIT_FLAG_A = 15;
  localparam int BIT_FLAG_B = 14;
  localparam int BIT_POST_A = 10;
  localparam int BIT_DCMP_B = 7;
  localparam int BIT_POST_B = 6;
  localparam int BIT_CHAIN  = 3;
  localparam int BIT_ENABLE = 0;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_A_ADR  = 3'd1,
    SEL_A_AMSK = 3'd2,
    SEL_B_ADR  = 3'd3,
    SEL_B_AMSK = 3'd4,
    SEL_B_DAT  = 3'd5,
    SEL_B_DMSK = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic post_a;
    logic post_b;
    logic dcmp_b;
    logic chain;
    logic enable;
  } cfg_t;

  // true when obs equals val on every bit not ignored
  function automatic logic masked_equal(input logic [CMP_MAX_W-1:0] obs,
                                        input logic [CMP_MAX_W-1:0] val,
                                        input logic [CMP_MAX_W-1:0] ign);
    return ((obs ^ val) & ~ign) == '0;
  endfunction

  // assemble the software view of the control register
  function automatic logic [CTRL_W-1:0] pack_ctrl(input logic flag_a,
                                                  input logic flag_b,
                                                  input cfg_t c);
    logic [CTRL_W-1:0] v;
    v             = '0;
    v[BIT_FLAG_A] = flag_a;
    v[BIT_FLAG_B] = flag_b;
    v[BIT_POST_A] = c.post_a;
    v[BIT_DCMP_B] = c.dcmp_b;
    v[BIT_POST_B] = c.post_b;
    v[BIT_CHAIN]  = c.chain;
    v[BIT_ENABLE] = c.enable;
    return v;
  endfunction

endpackage

// File: rtl/dbgbrk_regs.sv
module dbgbrk_regs
  import dbgbrk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_a,
  input  logic          ev_b,
  output cfg_t          cfg,
  output logic          flag_a,
  output logic          flag_b,
  output logic [AW-1:0] a_adr,
  output logic [AW-1:0] a_amsk,
  output logic [AW-1:0] b_adr,
  output logic [AW-1:0] b_amsk,
  output logic [DW-1:0] b_dat,
  output logic [DW-1:0] b_dmsk
);

  logic wr_ctrl;
  logic clr_a, clr_b;
  logic post_a_q, post_b_q, dcmp_b_q, chain_q, enable_q;

  assign wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
  assign clr_a   = wr_ctrl && !reg_wdata[BIT_FLAG_A];
  assign clr_b   = wr_ctrl && !reg_wdata[BIT_FLAG_B];

  // flags and enable: power-on reset, match beats clearing write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a   <= 1'b0;
      flag_b   <= 1'b0;
      enable_q <= 1'b0;
    end else begin
      flag_a <= ev_a | (flag_a & ~clr_a);
      flag_b <= ev_b | (flag_b & ~clr_b);
      if (wr_ctrl) enable_q <= reg_wdata[BIT_ENABLE];
    end
  end

  // mode bits carry no reset; software programs them before use
  always_ff @(posedge clk) begin
    if (wr_ctrl) begin
      post_a_q <= reg_wdata[BIT_POST_A];
      post_b_q <= reg_wdata[BIT_POST_B];
      dcmp_b_q <= reg_wdata[BIT_DCMP_B];
      chain_q  <= reg_wdata[BIT_CHAIN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_adr  <= '0;
      a_amsk <= '0;
      b_adr  <= '0;
      b_amsk <= '0;
      b_dat  <= '0;
      b_dmsk <= '0;
    end else if (reg_we) begin
      case (reg_sel_e'(reg_sel))
        SEL_A_ADR:  a_adr  <= reg_wdata[AW-1:0];
        SEL_A_AMSK: a_amsk <= reg_wdata[AW-1:0];
        SEL_B_ADR:  b_adr  <= reg_wdata[AW-1:0];
        SEL_B_AMSK: b_amsk <= reg_wdata[AW-1:0];
        SEL_B_DAT:  b_dat  <= reg_wdata;
        SEL_B_DMSK: b_dmsk <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg.post_a = post_a_q;
    cfg.post_b = post_b_q;
    cfg.dcmp_b = dcmp_b_q;
    cfg.chain  = chain_q;
    cfg.enable = enable_q;
  end

  always_comb begin
    case (reg_sel_e'(reg_sel))
      SEL_CTRL:   reg_rdata = DW'(pack_ctrl(flag_a, flag_b, cfg));
      SEL_A_ADR:  reg_rdata = DW'(a_adr);
      SEL_A_AMSK: reg_rdata = DW'(a_amsk);
      SEL_B_ADR:  reg_rdata = DW'(b_adr);
      SEL_B_AMSK: reg_rdata = DW'(b_amsk);
      SEL_B_DAT:  reg_rdata = b_dat;
      SEL_B_DMSK: reg_rdata = b_dmsk;
      default:    reg_rdata = '0;
    endcase
  end

  AST_FLAG_A_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_a |=> flag_a);                                           // R9
  AST_FLAG_B_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_b |=> flag_b);                                           // R9
  AST_FLAG_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_a && !(reg_we && reg_sel == 3'd0 && !reg_wdata[BIT_FLAG_A]))
      |=> flag_a);                                              // R9
  AST_FLAG_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_b && !(reg_we && reg_sel == 3'd0 && !reg_wdata[BIT_FLAG_B]))
      |=> flag_b);                                              // R9

endmodule

// File: rtl/dbgbrk_chan.sv
module dbgbrk_chan
  import dbgbrk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          post,
  input  logic          dcmp,
  input  logic [AW-1:0] adr,
  input  logic [AW-1:0] amsk,
  input  logic [DW-1:0] dat,
  input  logic [DW-1:0] dmsk,
  input  logic          bus_valid,
  input  logic          bus_ifetch,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_addr,
  input  logic [DW-1:0] ret_data,
  output logic          cond,
  output logic          ev
);

  logic          src_valid;
  logic [AW-1:0] src_addr;
  logic [DW-1:0] src_data;
  logic          addr_ok;
  logic          data_ok;
  logic          pend;

  // pre-execution channels watch fetches, post-execution ones watch completions
  assign src_valid = post ? ret_valid : (bus_valid & bus_ifetch);
  assign src_addr  = post ? ret_addr  : bus_addr;
  assign src_data  = post ? ret_data  : bus_data;

  assign addr_ok = masked_equal(CMP_MAX_W'(src_addr), CMP_MAX_W'(adr),
                                CMP_MAX_W'(amsk));

  generate
    if (HAS_DATA) begin : g_data
      assign data_ok = !dcmp ||
                       masked_equal(CMP_MAX_W'(src_data), CMP_MAX_W'(dat),
                                    CMP_MAX_W'(dmsk));
    end else begin : g_nodata
      logic unused_data;
      assign unused_data = ^{dcmp, dat, dmsk, src_data};
      assign data_ok     = 1'b1;
    end
  endgenerate

  assign cond = src_valid & addr_ok & data_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= post & cond;
  end

  assign ev = post ? pend : cond;

  AST_PRE_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!post && ev) |-> (bus_valid && bus_ifetch));               // R5
  AST_POST_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
    (post && cond) |=> (!post || ev));                          // R6
  AST_POST_NEEDS_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (post && cond) |-> ret_valid);                              // R6

endmodule

// File: rtl/dbgbrk_seq.sv
module dbgbrk_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic chain,
  input  logic enable,
  input  logic ev_a,
  input  logic ev_b,
  output logic armed,
  output logic brk_req
);

  logic fire_ind;
  logic fire_chain;

  assign fire_ind   = ev_a | ev_b;
  assign fire_chain = armed & ev_b;
  assign brk_req    = enable & (chain ? fire_chain : fire_ind);

  // A arms; an armed B match consumes it; a fresh A re-arms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= chain & (ev_a | (armed & ~ev_b));
  end

  AST_BRK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> enable);                                        // R10
  AST_INDEP_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain && enable && (ev_a || ev_b)) |-> brk_req);          // R7
  AST_CHAIN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && brk_req) |-> (armed && ev_b));                    // R8
  AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && armed && ev_b && !ev_a) |=> !armed);              // R8

endmodule

// File: rtl/dbgbrk_top.sv
module dbgbrk_top
  import dbgbrk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          bus_valid,
  input  logic          bus_ifetch,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_addr,
  input  logic [DW-1:0] ret_data,
  output logic          brk_req
);

  cfg_t          cfg;
  logic          flag_a, flag_b;
  logic [AW-1:0] a_adr, a_amsk, b_adr, b_amsk;
  logic [DW-1:0] b_dat, b_dmsk;
  logic          cond_a, cond_b;
  logic          ev_a, ev_b;
  logic          armed;

  dbgbrk_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ev_a      (ev_a),
    .ev_b      (ev_b),
    .cfg       (cfg),
    .flag_a    (flag_a),
    .flag_b    (flag_b),
    .a_adr     (a_adr),
    .a_amsk    (a_amsk),
    .b_adr     (b_adr),
    .b_amsk    (b_amsk),
    .b_dat     (b_dat),
    .b_dmsk    (b_dmsk)
  );

  dbgbrk_chan #(.AW(AW), .DW(DW), .HAS_DATA(1'b0)) u_chan_a (
    .clk        (clk),
    .rst_n      (rst_n),
    .post       (cfg.post_a),
    .dcmp       (1'b0),
    .adr        (a_adr),
    .amsk       (a_amsk),
    .dat        ({DW{1'b0}}),
    .dmsk       ({DW{1'b0}}),
    .bus_valid  (bus_valid),
    .bus_ifetch (bus_ifetch),
    .bus_addr   (bus_addr),
    .bus_data   (bus_data),
    .ret_valid  (ret_valid),
    .ret_addr   (ret_addr),
    .ret_data   (ret_data),
    .cond       (cond_a),
    .ev         (ev_a)
  );

  dbgbrk_chan #(.AW(AW), .DW(DW), .HAS_DATA(1'b1)) u_chan_b (
    .clk        (clk),
    .rst_n      (rst_n),
    .post       (cfg.post_b),
    .dcmp       (cfg.dcmp_b),
    .adr        (b_adr),
    .amsk       (b_amsk),
    .dat        (b_dat),
    .dmsk       (b_dmsk),
    .bus_valid  (bus_valid),
    .bus_ifetch (bus_ifetch),
    .bus_addr   (bus_addr),
    .bus_data   (bus_data),
    .ret_valid  (ret_valid),
    .ret_addr   (ret_addr),
    .ret_data   (ret_data),
    .cond       (cond_b),
    .ev         (ev_b)
  );

  dbgbrk_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .chain   (cfg.chain),
    .enable  (cfg.enable),
    .ev_a    (ev_a),
    .ev_b    (ev_b),
    .armed   (armed),
    .brk_req (brk_req)
  );

  AST_FLAGS_CLEAR_AT_RESET: assert property (@(posedge clk)
    $rose(rst_n) |-> (!flag_a && !flag_b && !cfg.enable));      // R1
  AST_COND_A_OBSERVED: assert property (@(posedge clk) disable iff (!rst_n)
    cond_a |-> (bus_valid || ret_valid));                       // R3
  AST_COND_B_OBSERVED: assert property (@(posedge clk) disable iff (!rst_n)
    cond_b |-> (bus_valid || ret_valid));                       // R4
  AST_ARM_ONLY_CHAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cfg.chain) |=> !armed);                          // R8

endmodule

// File: tb/sim_dbgbrk_top.sv
module sim_dbgbrk_top;

  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0;
  logic        bus_ifetch = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_data = '0;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_addr = '0;
  logic [31:0] ret_data = '0;
  logic        brk_req;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // model state
  logic        m_fa = 0, m_fb = 0, m_en = 0, m_pa = 0, m_pb = 0, m_dc = 0, m_ch = 0;
  logic        m_armed = 0, m_pendA = 0, m_pendB = 0;
  logic [31:0] m_reg [1:6];

  dbgbrk_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_ifetch(bus_ifetch), .bus_addr(bus_addr), .bus_data(bus_data),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_data(ret_data),
    .brk_req(brk_req)
  );

  always #(PER/2) clk = ~clk;

  // bit-by-bit restatement of the masked compare
  function automatic logic f_match(input logic [31:0] obs, val, ign);
    for (int i = 0; i < 32; i++)
      if (!ign[i] && (obs[i] != val[i])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] f_read(input int sel);
    if (sel == 0)
      return {16'h0, m_fa, m_fb, 3'b000, m_pa, 2'b00, m_dc, m_pb, 2'b00, m_ch, 2'b00, m_en};
    if (sel >= 1 && sel <= 6) return m_reg[sel];
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic bv, bif, input logic [31:0] ba, bd,
                       input logic rv, input logic [31:0] ra, rd,
                       input logic we, input int sel, input logic [31:0] wd,
                       input logic do_rd);
    logic cA, cB, eA, eB, exp_brk, wc;
    @(negedge clk);
    bus_valid = bv; bus_ifetch = bif; bus_addr = ba; bus_data = bd;
    ret_valid = rv; ret_addr = ra; ret_data = rd;
    reg_we = we; reg_sel = 3'(sel); reg_wdata = wd;
    #(PER/4);
    cA = (m_pa ? rv : (bv & bif)) && f_match(m_pa ? ra : ba, m_reg[1], m_reg[2]);
    cB = (m_pb ? rv : (bv & bif)) && f_match(m_pb ? ra : ba, m_reg[3], m_reg[4])
         && (!m_dc || f_match(m_pb ? rd : bd, m_reg[5], m_reg[6]));
    eA = m_pa ? m_pendA : cA;
    eB = m_pb ? m_pendB : cB;
    exp_brk = m_en && (m_ch ? (m_armed && eB) : (eA || eB));
    chk(cur_req, {31'h0, brk_req}, {31'h0, exp_brk});
    if (do_rd) chk(cur_req, reg_rdata, f_read(sel));
    wc = we && sel == 0;
    m_pendA = m_pa && cA;
    m_pendB = m_pb && cB;
    m_armed = m_ch && (eA || (m_armed && !eB));
    m_fa = eA || (m_fa && !(wc && !wd[15]));
    m_fb = eB || (m_fb && !(wc && !wd[14]));
    if (wc) begin
      m_en = wd[0]; m_pa = wd[10]; m_pb = wd[6]; m_dc = wd[7]; m_ch = wd[3];
    end
    if (we && sel >= 1 && sel <= 6) m_reg[sel] = wd;
  endtask

  task automatic idle();             cycle(0,0,0,0,0,0,0,0,0,0,0); endtask
  task automatic fetch(input logic [31:0] a, d);   cycle(1,1,a,d,0,0,0,0,0,0,0); endtask
  task automatic operand(input logic [31:0] a, d); cycle(1,0,a,d,0,0,0,0,0,0,0); endtask
  task automatic retire(input logic [31:0] a, d);  cycle(0,0,0,0,1,a,d,0,0,0,0); endtask
  task automatic wr(input int sel, input logic [31:0] v); cycle(0,0,0,0,0,0,0,1,sel,v,0); endtask
  task automatic rd(input int sel);  cycle(0,0,0,0,0,0,0,0,sel,0,1); endtask

  // control word helper: en, chain, postA, postB, dcmp; flags written 1 (keep)
  function automatic logic [31:0] ctl(input logic en, ch, pa, pb, dc);
    return {16'h0, 1'b1, 1'b1, 3'b000, pa, 2'b00, dc, pb, 2'b00, ch, 2'b00, en};
  endfunction

  initial begin
    #(PER*200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 1; i <= 6; i++) m_reg[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #(PER/4);
    // R1: flags and enable cleared, no break
    reg_sel = 3'd0; #1;
    chk("R1", reg_rdata & 32'h0000_C001, 32'h0);
    chk("R1", {31'h0, brk_req}, 32'h0);

    // R2: register readback and reserved control bits
    cur_req = "R2";
    wr(0, 32'hFFFF_FFFF & ~32'h0000_C000);
    rd(0);
    wr(1, 32'h1234_5678); wr(2, 32'h0000_00FF); wr(3, 32'hCAFE_0000);
    wr(4, 32'h0000_000F); wr(5, 32'hA5A5_5A5A); wr(6, 32'h0F0F_F0F0);
    for (int s = 1; s <= 6; s++) rd(s);

    // R3 + R5: channel A pre-execution, masked address
    cur_req = "R3";
    wr(0, ctl(1,0,0,0,0));
    wr(1, 32'h0000_1000); wr(2, 32'h0000_000F);
    wr(3, 32'hFFFF_0000); wr(4, 32'h0);
    fetch(32'h0000_100C, 0);
    fetch(32'h0000_1010, 0);
    fetch(32'h0000_1000, 0);
    cur_req = "R5";
    operand(32'h0000_1000, 0);
    idle();

    // R6: post-execution on A: break one cycle after the report
    cur_req = "R6";
    wr(0, ctl(1,0,1,0,0));
    retire(32'h0000_1004, 0);
    idle();
    fetch(32'h0000_1004, 0);
    idle();

    // R4: channel B data compare, byte duplicated in bits 15-8 and 7-0
    cur_req = "R4";
    wr(0, ctl(1,0,0,0,1));
    wr(3, 32'h0000_2000); wr(4, 32'h0);
    wr(5, 32'h0000_3C3C); wr(6, 32'hFFFF_0000);
    fetch(32'h0000_2000, 32'h9999_3C3C);
    fetch(32'h0000_2000, 32'h0000_3C3D);
    wr(0, ctl(1,0,0,0,0));
    fetch(32'h0000_2000, 32'h0000_3C3D);
    idle();

    // R7: independent channels
    cur_req = "R7";
    fetch(32'h0000_1008, 0);
    fetch(32'h0000_2000, 0);

    // R8: chained mode
    cur_req = "R8";
    wr(0, ctl(1,1,0,0,0));
    fetch(32'h0000_2000, 0);
    fetch(32'h0000_1000, 0);
    idle();
    fetch(32'h0000_2000, 0);
    fetch(32'h0000_2000, 0);
    fetch(32'h0000_1000, 0);
    wr(0, ctl(1,0,0,0,0));

    // R9: flag clear by 0, keep by 1, set wins
    cur_req = "R9";
    fetch(32'h0000_1000, 0);
    fetch(32'h0000_2000, 0);
    rd(0);
    wr(0, ctl(1,0,0,0,0));
    rd(0);
    wr(0, ctl(1,0,0,0,0) & ~32'h0000_4000);
    rd(0);
    cycle(1,1,32'h0000_1000,0,0,0,0,1,0,ctl(1,0,0,0,0) & ~32'h0000_C000,0);
    rd(0);

    // R10: disabled, flags still recorded
    cur_req = "R10";
    wr(0, ctl(0,0,0,0,0) & ~32'h0000_C000);
    fetch(32'h0000_2000, 0);
    fetch(32'h0000_1000, 0);
    rd(0);

    // random traffic mixed with reconfiguration
    cur_req = "R7/R8 random";
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [31:0] a, d;
      k = $urandom % 32;
      case ($urandom % 4)
        0: a = m_reg[1] ^ ($urandom & 32'h0000_001F);
        1: a = m_reg[3] ^ ($urandom & 32'h0000_001F);
        2: a = $urandom;
        default: a = m_reg[1];
      endcase
      d = ($urandom % 2) ? (m_reg[5] ^ ($urandom & 32'h0001_0101)) : $urandom;
      if (k == 0)
        cycle($urandom%2, $urandom%2, a, d, $urandom%2, a, d, 1, 0,
              $urandom & 32'h0000_FFFF, 0);
      else if (k == 1)
        wr(1 + $urandom % 6, ($urandom % 2) ? ($urandom & 32'h0000_000F) : $urandom);
      else if (k < 5)
        rd($urandom % 8);
      else
        cycle($urandom%2, $urandom%2, a, d, $urandom%2, a, d, 0, 0, 0, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule